// File: doc/BRIEF.md
# Dual-Compare 8-bit Timer/Counter

This block is an 8-bit up-counter that advances on each cycle in which a timer tick enable is high. It has two compare channels, A and B. On every tick, each channel checks its own 8-bit compare value against the count the counter holds in that cycle. A match sets a sticky flag for that channel. If the channel's toggle mode is on, the match also inverts that channel's waveform output.

A small register bus gives the host full access. The host writes with a single-cycle strobe and reads through a combinational read port. Through this bus it can load the counter and both compare values, set the per-channel interrupt enable and toggle mode bits, and clear flags. Loading the counter suppresses compare matches on the next timer tick. Because of this, a match can be lost when the count is rewritten while the timer runs.

Each channel has an interrupt request output. It is high while that channel's flag and its enable bit are both set.

Top module: `dual_cmp_timer`

## Requirements
- R1: While `rst` is high at a clock edge, the counter, both compare values, the control register, both flags and both waveform outputs become zero. As a result, every readable register and every output reads 0 after reset.
- R2: The counter increments by one at each clock edge where `tick` is high and no counter write occurs. It wraps from 255 to 0. It holds its value when `tick` is low.
- R3: A bus write to address 0 loads `bus_wdata` into the counter. If a tick falls in the same cycle, the written value is kept and the tick does not increment it.
- R4: The register map is as follows. Address 0 is the counter, address 1 is compare A and address 2 is compare B. Address 3 is control, with bit 0 = enable A, bit 1 = enable B, bit 2 = toggle A and bit 3 = toggle B. Address 4 is flags, with bit 0 = A and bit 1 = B. Reads return the current contents and other addresses read 0.
- R5: A tick in a cycle where the counter equals a channel's compare value sets that channel's flag from the next cycle onward. The flag stays set until it is cleared.
- R6: Writing flags with a 1 in a bit position clears that channel's flag, while a 0 leaves it unchanged. If a match and a clear fall in the same cycle, the flag stays set.
- R7: `irq[i]` is high exactly when flag i and enable i are both set.
- R8: On a match, `wave[i]` inverts if toggle i is set. If toggle i is clear, `wave[i]` does not change.
- R9: After a counter write, the next tick produces no match on either channel, so it changes no flag and no waveform. Ticks after that one compare normally.
- R10: The two channels act independently, and a match on one leaves the other's flag and waveform unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer clock enable; one count step per high cycle |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_addr | input | 3 | Register address (read and write) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| irq | output | 2 | Interrupt requests, bit 0 = channel A |
| wave | output | 2 | Waveform outputs, bit 0 = channel A |

## Verification
The bench loads the counter with the value that sits in a compare register. It then checks that the following tick leaves both flags and waveforms untouched. A design that ignored the suppression would raise a flag here. It also checks that the tick after that matches normally, which catches a design that blocked matches for too long.

A counter write that coincides with a tick must keep the written value; a design that let the increment win would read one higher. A flag clear that coincides with a match must leave the flag set; a design that let the clear win would miss an interrupt. The wrap from 255 to 0 and a channel with toggling off are also checked. An off-by-one in the wrap would skip or repeat a value, and a wrong toggle gate would move the waveform anyway.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

    localparam int NCH    = 2;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_COUNT = 3'd0,
        SEL_CMP_A = 3'd1,
        SEL_CMP_B = 3'd2,
        SEL_CTRL  = 3'd3,
        SEL_FLAGS = 3'd4
    } reg_sel_e;

    // control register: enables in the low bits, toggle modes above
    typedef struct packed {
        logic [NCH-1:0] tgl;
        logic [NCH-1:0] ie;
    } ctrl_t;

    typedef struct packed {
        logic           cnt_we;
        logic [NCH-1:0] cmp_we;
        logic           ctrl_we;
        logic           flag_we;
    } wr_dec_t;

    function automatic wr_dec_t decode_wr(input logic wr, input logic [ADDR_W-1:0] addr);
        wr_dec_t d;
        d.cnt_we    = wr && (addr == SEL_COUNT);
        d.cmp_we[0] = wr && (addr == SEL_CMP_A);
        d.cmp_we[1] = wr && (addr == SEL_CMP_B);
        d.ctrl_we   = wr && (addr == SEL_CTRL);
        d.flag_we   = wr && (addr == SEL_FLAGS);
        return d;
    endfunction

endpackage

// File: rtl/dtc_counter.sv
module dtc_counter
    import dtc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         blocked
);

    logic [W-1:0] cnt_q;
    logic         blk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            blk_q <= 1'b0;
        end else if (load) begin
            // host write wins over a coincident tick
            cnt_q <= load_val;
            blk_q <= 1'b1;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
            blk_q <= 1'b0;
        end
    end

    assign count   = cnt_q;
    assign blocked = blk_q;

    a_r1_count_reset: assert property (@(posedge clk) rst |=> cnt_q == '0);

    a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
        (tick && !load) |=> cnt_q == W'($past(cnt_q) + 1'b1));

    a_r2_count_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(cnt_q));

    a_r3_count_load: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == $past(load_val)) && blk_q);

endmodule

// File: rtl/dtc_channel.sv
module dtc_channel
    import dtc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         blocked,
    input  logic [W-1:0] count,
    input  logic [W-1:0] cmp,
    input  logic         clr,
    input  logic         tgl_en,
    input  logic         ie,
    output logic         flag,
    output logic         wave,
    output logic         irq
);

    logic hit;
    logic flag_q;
    logic wave_q;

    assign hit = tick && !blocked && (count == cmp);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            wave_q <= 1'b0;
        end else begin
            if (hit)
                flag_q <= 1'b1;   // set beats clear
            else if (clr)
                flag_q <= 1'b0;
            if (hit && tgl_en)
                wave_q <= ~wave_q;
        end
    end

    assign flag = flag_q;
    assign wave = wave_q;
    assign irq  = flag_q & ie;

    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr) |=> flag_q);

    a_r8_wave_hold: assert property (@(posedge clk) disable iff (rst)
        !tgl_en |=> $stable(wave_q));

    a_r9_blocked_quiet: assert property (@(posedge clk) disable iff (rst)
        (tick && blocked) |=> !$rose(flag_q) && $stable(wave_q));

endmodule

// File: rtl/dtc_regfile.sv
module dtc_regfile
    import dtc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  wr_dec_t                 dec,
    input  logic [W-1:0]            wdata,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [W-1:0]            count,
    input  logic [NCH-1:0]          flags,
    output logic [NCH-1:0][W-1:0]   cmp,
    output ctrl_t                   ctrl,
    output logic [W-1:0]            rdata
);

    localparam int CTRL_W = $bits(ctrl_t);

    for (genvar i = 0; i < NCH; i++) begin : g_cmp
        logic [W-1:0] cmp_q;
        always_ff @(posedge clk) begin
            if (rst)
                cmp_q <= '0;
            else if (dec.cmp_we[i])
                cmp_q <= wdata;
        end
        assign cmp[i] = cmp_q;

        a_r4_cmp_load: assert property (@(posedge clk) disable iff (rst)
            dec.cmp_we[i] |=> cmp_q == $past(wdata));
    end

    ctrl_t ctrl_q;
    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (dec.ctrl_we)
            ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
    end
    assign ctrl = ctrl_q;

    always_comb begin
        rdata = '0;
        case (reg_sel_e'(addr))
            SEL_COUNT: rdata = count;
            SEL_CMP_A: rdata = cmp[0];
            SEL_CMP_B: rdata = cmp[1];
            SEL_CTRL:  rdata[CTRL_W-1:0] = ctrl_q;
            SEL_FLAGS: rdata[NCH-1:0] = flags;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
    import dtc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    output logic [NCH-1:0]    irq,
    output logic [NCH-1:0]    wave
);

    wr_dec_t              dec;
    logic [W-1:0]         count;
    logic                 blocked;
    logic [NCH-1:0][W-1:0] cmp;
    ctrl_t                ctrl;
    logic [NCH-1:0]       flags;
    logic [NCH-1:0]       clr;

    assign dec = decode_wr(bus_wr, bus_addr);
    assign clr = {NCH{dec.flag_we}} & bus_wdata[NCH-1:0];

    dtc_counter #(.W(W)) u_counter (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load     (dec.cnt_we),
        .load_val (bus_wdata),
        .count    (count),
        .blocked  (blocked)
    );

    dtc_regfile #(.W(W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .dec   (dec),
        .wdata (bus_wdata),
        .addr  (bus_addr),
        .count (count),
        .flags (flags),
        .cmp   (cmp),
        .ctrl  (ctrl),
        .rdata (bus_rdata)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        dtc_channel #(.W(W)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick),
            .blocked (blocked),
            .count   (count),
            .cmp     (cmp[i]),
            .clr     (clr[i]),
            .tgl_en  (ctrl.tgl[i]),
            .ie      (ctrl.ie[i]),
            .flag    (flags[i]),
            .wave    (wave[i]),
            .irq     (irq[i])
        );
    end

    a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
        ((irq & ~flags) == '0));

endmodule

// File: tb/test_dual_cmp_timer.sv
module test_dual_cmp_timer;

    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2, OP_PIN = 2'd3;
    localparam logic [2:0] A_CNT = 3'd0, A_CA = 3'd1, A_CB = 3'd2, A_CTL = 3'd3, A_FLG = 3'd4;
    localparam int NV = 27;

    // {op, addr, data, expected}; PIN expects {wave[1:0], irq[1:0]}
    localparam logic [20:0] VEC [NV] = '{
        {OP_WR,  A_CTL, 8'h0F, 8'h00},  // enables and toggles on
        {OP_WR,  A_CA,  8'h05, 8'h00},
        {OP_WR,  A_CB,  8'h07, 8'h00},
        {OP_RD,  A_CA,  8'h00, 8'h05},  // R4
        {OP_RD,  A_CB,  8'h00, 8'h07},  // R4
        {OP_RD,  A_CTL, 8'h00, 8'h0F},  // R4
        {OP_RD,  3'd6,  8'h00, 8'h00},  // R4 unmapped
        {OP_WR,  A_CNT, 8'h03, 8'h00},  // R3
        {OP_TK,  3'd0,  8'h00, 8'h00},  // blocked tick, 3 -> 4
        {OP_RD,  A_CNT, 8'h00, 8'h04},  // R2
        {OP_TK,  3'd0,  8'h00, 8'h00},  // 4 -> 5
        {OP_TK,  3'd0,  8'h00, 8'h00},  // 5 matches A
        {OP_PIN, 3'd0,  8'h00, 8'h05},  // R5 R8 R10
        {OP_RD,  A_FLG, 8'h00, 8'h01},  // R5
        {OP_TK,  3'd0,  8'h00, 8'h00},  // 6
        {OP_TK,  3'd0,  8'h00, 8'h00},  // 7 matches B
        {OP_PIN, 3'd0,  8'h00, 8'h0F},  // R10
        {OP_WR,  A_FLG, 8'h01, 8'h00},  // clear A
        {OP_PIN, 3'd0,  8'h00, 8'h0E},  // R6
        {OP_WR,  A_FLG, 8'h00, 8'h00},  // writing 0 clears nothing
        {OP_RD,  A_FLG, 8'h00, 8'h02},  // R6
        {OP_WR,  A_CTL, 8'h01, 8'h00},  // only enable A, toggles off
        {OP_PIN, 3'd0,  8'h00, 8'h0C},  // R7 flag B set but masked
        {OP_WR,  A_CNT, 8'h04, 8'h00},
        {OP_TK,  3'd0,  8'h00, 8'h00},  // blocked, 4 -> 5
        {OP_TK,  3'd0,  8'h00, 8'h00},  // 5 matches A, no toggle
        {OP_PIN, 3'd0,  8'h00, 8'h0D}   // R7 R8
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] irq;
    logic [1:0] wave;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dual_cmp_timer i_dual_cmp_timer (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .wave      (wave)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic w, input logic [2:0] a, input logic [7:0] d, input logic t);
        @(negedge clk);
        bus_wr = w; bus_addr = a; bus_wdata = d; tick = t;
        @(negedge clk);
        bus_wr = 1'b0; tick = 1'b0;
    endtask

    task automatic rd(input string req, input logic [2:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic pins(input string req, input logic [3:0] exp);
        #1;
        check(req, {4'b0, wave, irq}, {4'b0, exp});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [1:0] w0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        rd("R1 count", A_CNT, 8'h00);
        rd("R1 cmpA", A_CA, 8'h00);
        rd("R1 cmpB", A_CB, 8'h00);
        rd("R1 ctrl", A_CTL, 8'h00);
        rd("R1 flags", A_FLG, 8'h00);
        pins("R1 pins", 4'h0);

        for (int k = 0; k < NV; k++) begin
            logic [1:0] op;
            logic [2:0] a;
            logic [7:0] d, e;
            {op, a, d, e} = VEC[k];
            case (op)
                OP_WR: cyc(1'b1, a, d, 1'b0);
                OP_TK: cyc(1'b0, 3'd0, 8'h00, 1'b1);
                OP_RD: rd($sformatf("R4 vector %0d read", k), a, e);
                default: pins($sformatf("R5-group vector %0d pins", k), e[3:0]);
            endcase
        end

        // R2: wrap and hold
        cyc(1'b1, A_CTL, 8'h00, 1'b0);
        cyc(1'b1, A_CNT, 8'hFE, 1'b0);
        cyc(1'b0, 3'd0, 8'h00, 1'b1);
        cyc(1'b0, 3'd0, 8'h00, 1'b1);
        rd("R2 wrap to 0", A_CNT, 8'h00);
        repeat (3) cyc(1'b0, 3'd0, 8'h00, 1'b0);
        rd("R2 hold without tick", A_CNT, 8'h00);

        // R3: write coinciding with tick keeps the written value
        cyc(1'b1, A_CNT, 8'h10, 1'b1);
        rd("R3 write beats tick", A_CNT, 8'h10);

        // R9: loading a matching value suppresses the next tick's match
        cyc(1'b1, A_CTL, 8'h0F, 1'b0);
        cyc(1'b1, A_CA, 8'h40, 1'b0);
        cyc(1'b1, A_CB, 8'h40, 1'b0);
        cyc(1'b1, A_FLG, 8'h03, 1'b0);
        #1 w0 = wave;
        cyc(1'b1, A_CNT, 8'h40, 1'b0);
        cyc(1'b0, 3'd0, 8'h00, 1'b1);
        rd("R9 no flag after blocked tick", A_FLG, 8'h00);
        check("R9 waves unchanged", {6'b0, wave}, {6'b0, w0});
        rd("R9 count still advances", A_CNT, 8'h41);
        cyc(1'b1, A_CNT, 8'h3F, 1'b0);
        cyc(1'b0, 3'd0, 8'h00, 1'b1);
        cyc(1'b0, 3'd0, 8'h00, 1'b1);
        rd("R9 later tick matches", A_FLG, 8'h03);
        check("R9 R10 waves toggled", {6'b0, wave}, {6'b0, ~w0});

        // R6: match wins over a coincident clear
        cyc(1'b1, A_CA, 8'h20, 1'b0);
        cyc(1'b1, A_CB, 8'h99, 1'b0);
        cyc(1'b1, A_CNT, 8'h1F, 1'b0);
        cyc(1'b0, 3'd0, 8'h00, 1'b1);
        cyc(1'b1, A_FLG, 8'h03, 1'b0);
        rd("R6 cleared", A_FLG, 8'h00);
        cyc(1'b1, A_FLG, 8'h01, 1'b1);
        rd("R6 set beats clear", A_FLG, 8'h01);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule